// File: doc/BRIEF.md
# GPIO Output Port with Atomic Bit Set and Clear

This block is the output side of a 16-pin general-purpose I/O port, placed on a simple 32-bit register bus that carries byte-lane strobes. It holds an output data register that drives the pins, and software can read and write that register directly. It also offers two write-only command registers. With them, any chosen group of output bits can be driven high or low in one bus write, without reading the port first. An interrupt handler and a main loop can therefore share the port without corrupting each other's bits.

The combined command word carries set controls in its low half and clear controls in its high half. That lets one write raise some pins and drop others in the same clock. A second word clears only: it uses its low half and discards its high half. The combined word accepts byte, half-word and word writes through the lane strobes, so either half can be written on its own. A read-only input register returns the pin levels after a two-stage synchronizer.

The bus address is a word index, and the lane strobes pick the bytes that a write affects. The byte offsets 0x10, 0x14, 0x18 and 0x1C map to word indices 4, 5, 6 and 7.

Top module: `gpio_out_atomic`

## Requirements
- R1: While `rst` is high and after it falls, with no write since, `pins_out` is 0 and `bus_rdata` is 0.
- R2: A write to the data register (byte offset 0x14, word 5) loads output bits 7:0 when strobe bit 0 is set and bits 15:8 when strobe bit 1 is set. Strobe bits 3:2 and data bits 31:16 have no effect. A read of word 5 returns the output register in bits 15:0, with zeros above.
- R3: A write to the combined command word (byte offset 0x18, word 6) drives to one every output bit n whose data bit n (n = 0..15) is one in an enabled lane.
- R4: In the same combined write, every output bit n whose data bit n+16 is one in an enabled lane is driven to zero. A single write can therefore set some bits and clear others.
- R5: If one combined write both sets and clears the same output bit, the bit ends at one.
- R6: A command write leaves every output bit that it does not command unchanged. Control bits in disabled lanes count as zero. A half-word write with strobe 0011 therefore only sets, and one with strobe 1100 (byte offset 0x1A) only clears.
- R7: A write to the clear-only word (byte offset 0x1C, word 7) drives to zero each output bit n whose data bit n is one in an enabled lane. Data bits 31:16 are ignored whatever their value, and no output bit ever rises.
- R8: Reads of words 6 and 7 return 0.
- R9: The input register (byte offset 0x10, word 4) returns the pins through two flip-flops. A pin change made just before clock edge k is returned by a read sampled at edge k+2 or later, and not by one sampled at edge k+1. Writes to word 4 leave the outputs unchanged.
- R10: A write changes `pins_out` at the same clock edge that samples `bus_wr`. Read data appears in `bus_rdata` after the edge that samples `bus_rd`, and `bus_rdata` is 0 after any edge without a read.
- R11: Writes to unmapped words leave `pins_out` unchanged, and reads of unmapped words return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W (6) | Word index of the register |
| bus_wstrb | input | DATA_W/8 (4) | Byte-lane write enables |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| pins_in | input | NPINS (16) | Asynchronous pin levels |
| pins_out | output | NPINS (16) | Output data register driving the pins |

## Verification
The bench builds the block with its defaults: 16 pins, a 32-bit bus and two synchronizer stages. With these values each control half fills exactly one pair of byte lanes, so every byte and half-word strobe pattern splits set and clear controls cleanly and lands on a real boundary. The two-stage depth puts the exact cycle at which a pin change first appears within reach of one directed check on each side of that cycle. Random strobes and data drive collisions between set and clear, as well as garbage in the ignored upper half of the clear-only word.

// File: rtl/gpio_atom_pkg.sv
package gpio_atom_pkg;

  // Byte offsets of the port registers; the bus carries word indices.
  localparam int unsigned OFS_IN  = 32'h10;
  localparam int unsigned OFS_OUT = 32'h14;
  localparam int unsigned OFS_SR  = 32'h18;
  localparam int unsigned OFS_CLR = 32'h1C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_IN,
    SEL_OUT,
    SEL_SR,
    SEL_CLR
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input int unsigned word_idx);
    reg_sel_e s;
    if (word_idx == (OFS_IN >> 2))       s = SEL_IN;
    else if (word_idx == (OFS_OUT >> 2)) s = SEL_OUT;
    else if (word_idx == (OFS_SR >> 2))  s = SEL_SR;
    else if (word_idx == (OFS_CLR >> 2)) s = SEL_CLR;
    else                                 s = SEL_NONE;
    return s;
  endfunction

endpackage

// File: rtl/gpio_wr_decode.sv
module gpio_wr_decode
  import gpio_atom_pkg::*;
#(
  parameter int NPINS  = 16,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                  wr,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W/8-1:0]   strb,
  input  logic [DATA_W-1:0]     wdata,
  output logic [NPINS-1:0]      set_m,
  output logic [NPINS-1:0]      clr_m,
  output logic [NPINS-1:0]      ld_m,
  output logic [NPINS-1:0]      ld_v
);
  localparam int LANES = DATA_W / 8;
  localparam int HALF  = DATA_W / 2;

  logic [DATA_W-1:0] lane_m;
  reg_sel_e          sel;

  // Expand each byte strobe into a mask over its eight data bits.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_m[8*g +: 8] = {8{strb[g]}};
  end

  assign sel  = decode_sel(32'(addr));
  assign ld_v = wdata[NPINS-1:0];

  always_comb begin
    set_m = '0;
    clr_m = '0;
    ld_m  = '0;
    if (wr) begin
      case (sel)
        SEL_OUT: ld_m = lane_m[NPINS-1:0];
        SEL_SR: begin
          set_m = wdata[NPINS-1:0] & lane_m[NPINS-1:0];
          clr_m = wdata[HALF +: NPINS] & lane_m[HALF +: NPINS];
        end
        SEL_CLR: clr_m = wdata[NPINS-1:0] & lane_m[NPINS-1:0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_odr.sv
module gpio_odr #(
  parameter int NPINS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] set_m,
  input  logic [NPINS-1:0] clr_m,
  input  logic [NPINS-1:0] ld_m,
  input  logic [NPINS-1:0] ld_v,
  output logic [NPINS-1:0] odr
);
  logic [NPINS-1:0] loaded;

  assign loaded = (odr & ~ld_m) | (ld_v & ld_m);

  // Clear is applied before set, so a bit asked for both ends high.
  always_ff @(posedge clk) begin
    if (rst) odr <= '0;
    else     odr <= (loaded & ~clr_m) | set_m;
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NPINS  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] din,
  output logic [NPINS-1:0] dout
);
  logic [NPINS-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[g] <= '0;
      else     stg[g] <= stg[g-1];
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/gpio_out_atomic.sv
module gpio_out_atomic
  import gpio_atom_pkg::*;
#(
  parameter int NPINS       = 16,
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W/8-1:0] bus_wstrb,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NPINS-1:0]    pins_in,
  output logic [NPINS-1:0]    pins_out
);
  logic [NPINS-1:0] set_m, clr_m, ld_m, ld_v;
  logic [NPINS-1:0] in_sync;
  reg_sel_e         rsel;

  gpio_wr_decode #(.NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .wr(bus_wr), .addr(bus_addr), .strb(bus_wstrb), .wdata(bus_wdata),
    .set_m(set_m), .clr_m(clr_m), .ld_m(ld_m), .ld_v(ld_v)
  );

  gpio_odr #(.NPINS(NPINS)) u_odr (
    .clk(clk), .rst(rst), .set_m(set_m), .clr_m(clr_m),
    .ld_m(ld_m), .ld_v(ld_v), .odr(pins_out)
  );

  gpio_in_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pins_in), .dout(in_sync)
  );

  assign rsel = decode_sel(32'(bus_addr));

  // Registered read port; command words read as zero.
  always_ff @(posedge clk) begin
    if (rst || !bus_rd) begin
      bus_rdata <= '0;
    end else begin
      case (rsel)
        SEL_IN:  bus_rdata <= DATA_W'(in_sync);
        SEL_OUT: bus_rdata <= DATA_W'(pins_out);
        default: bus_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_out_atomic_chk.sv
module gpio_out_atomic_chk #(
  parameter int NPINS  = 16,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W/8-1:0] bus_wstrb,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [NPINS-1:0]    pins_out
);
  localparam int HALF = DATA_W / 2;
  localparam logic [ADDR_W-1:0] A_OUT = ADDR_W'(gpio_atom_pkg::OFS_OUT >> 2);
  localparam logic [ADDR_W-1:0] A_SR  = ADDR_W'(gpio_atom_pkg::OFS_SR >> 2);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(gpio_atom_pkg::OFS_CLR >> 2);

  logic [DATA_W-1:0] lane;
  logic              w_sr, w_clr, w_out, rst_q;
  logic [NPINS-1:0]  set_e, clr_e;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) lane[i] = bus_wstrb[i/8];
  end

  assign w_sr  = bus_wr && (bus_addr == A_SR);
  assign w_clr = bus_wr && (bus_addr == A_CLR);
  assign w_out = bus_wr && (bus_addr == A_OUT);
  assign set_e = w_sr ? (bus_wdata[NPINS-1:0] & lane[NPINS-1:0]) : '0;
  assign clr_e = w_sr  ? (bus_wdata[HALF +: NPINS] & lane[HALF +: NPINS]) :
                 w_clr ? (bus_wdata[NPINS-1:0] & lane[NPINS-1:0]) : '0;

  always_ff @(posedge clk) rst_q <= rst;

  always @(negedge clk) begin
    if (rst_q) begin
      p_reset_zero_r1: assert (pins_out == '0 && bus_rdata == '0)
        else $error("output or read data not zero after reset");
    end
  end

  p_set_bits_r3: assert property (@(posedge clk) disable iff (rst)
    w_sr |=> ((pins_out & $past(set_e)) == $past(set_e)));

  // R4 and R5: a commanded clear lands unless the same bit is also set.
  p_clear_bits_r4: assert property (@(posedge clk) disable iff (rst)
    (w_sr || w_clr) |=> ((pins_out & $past(clr_e & ~set_e)) == '0));

  p_keep_others_r6: assert property (@(posedge clk) disable iff (rst)
    (w_sr || w_clr) |=>
      (((pins_out ^ $past(pins_out)) & ~$past(set_e | clr_e)) == '0));

  p_clr_no_rise_r7: assert property (@(posedge clk) disable iff (rst)
    w_clr |=> ((pins_out & ~$past(pins_out)) == '0));

  p_cmd_read_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr == A_SR || bus_addr == A_CLR)) |=> (bus_rdata == '0));

  p_idle_stable_r11: assert property (@(posedge clk) disable iff (rst)
    !(w_sr || w_clr || w_out) |=> $stable(pins_out));

  p_rdata_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));

endmodule

bind gpio_out_atomic gpio_out_atomic_chk #(
  .NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wstrb(bus_wstrb), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .pins_out(pins_out)
);

// File: tb/gpio_out_atomic_bench.sv
`timescale 1ns/1ps
module gpio_out_atomic_bench;
  localparam int NP = 16;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam logic [AW-1:0] W_IN = 6'd4, W_OUT = 6'd5, W_SR = 6'd6,
                            W_CLR = 6'd7, W_NONE = 6'd9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [3:0]    bus_wstrb = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [NP-1:0] pins_in = '0;
  logic [NP-1:0] pins_out;

  int checks = 0;
  int errors = 0;
  logic [NP-1:0] exp_out = '0;

  always #4 clk = ~clk;

  gpio_out_atomic u_gpio_out_atomic (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wstrb(bus_wstrb), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pins_in(pins_in), .pins_out(pins_out)
  );

  task automatic check(input bit ok, input string req,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] lanes(input logic [3:0] s);
    return {{8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}};
  endfunction

  // Expected output register after one write, from the requirements.
  function automatic logic [NP-1:0] model(input logic [NP-1:0] cur,
      input logic [AW-1:0] a, input logic [3:0] s, input logic [DW-1:0] d);
    logic [DW-1:0] m = d & lanes(s);
    case (a)
      W_OUT: return (cur & ~lanes(s)[15:0]) | m[15:0];
      W_SR:  return (cur & ~m[31:16]) | m[15:0];
      W_CLR: return cur & ~m[15:0];
      default: return cur;
    endcase
  endfunction

  task automatic do_write(input logic [AW-1:0] a, input logic [3:0] s,
                          input logic [DW-1:0] d, input string req);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wstrb = s; bus_wdata = d;
    exp_out = model(exp_out, a, s, d);
    @(negedge clk);
    bus_wr = 1'b0;
    check(pins_out == exp_out, req, DW'(pins_out), DW'(exp_out));
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  initial begin
    #(200000 * 8);
    check(1'b0, "watchdog", '0, '0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] rv;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(pins_out == '0 && bus_rdata == '0, "R1 during reset",
          DW'(pins_out), '0);
    rst = 1'b0;
    @(negedge clk);
    check(pins_out == '0, "R1 after reset", DW'(pins_out), '0);
    do_read(W_OUT, rv);
    check(rv == '0, "R1 read after reset", rv, '0);

    // R2: lane writes to the data register; the upper lanes do nothing.
    do_write(W_OUT, 4'b1111, 32'hFFFF_A5C3, "R2 full write");
    do_write(W_OUT, 4'b0010, 32'h0000_1200, "R2 high byte");
    do_write(W_OUT, 4'b1100, 32'hFFFF_FFFF, "R2 upper lanes");
    do_read(W_OUT, rv);
    check(rv == DW'(exp_out), "R2 readback", rv, DW'(exp_out));

    // R10: no change before the sampling edge, change right after it.
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = W_SR; bus_wstrb = 4'hF; bus_wdata = 32'h0000_0001;
    #1;
    check(pins_out == exp_out, "R10 before edge", DW'(pins_out), DW'(exp_out));
    exp_out = model(exp_out, W_SR, 4'hF, 32'h0000_0001);
    @(negedge clk);
    bus_wr = 1'b0;
    check(pins_out == exp_out, "R10 after edge", DW'(pins_out), DW'(exp_out));
    check(bus_rdata == '0, "R10 rdata idle", bus_rdata, '0);

    do_write(W_OUT, 4'b0011, 32'h0000_0F0F, "R2 preset");
    do_write(W_SR, 4'hF, 32'h0000_F000, "R3 set high nibble");
    do_write(W_SR, 4'hF, 32'h000F_00F0, "R4 set and clear together");
    do_write(W_SR, 4'hF, 32'h8001_8001, "R5 set wins");
    check(pins_out[15] && pins_out[0], "R5 collision bits high",
          DW'(pins_out), DW'(exp_out));
    do_write(W_SR, 4'b0011, 32'hFFFF_0200, "R6 low half only sets");
    do_write(W_SR, 4'b1100, 32'h0F00_FFFF, "R6 high half only clears");
    do_write(W_SR, 4'b0100, 32'h00FF_FFFF, "R6 single byte clear");
    do_write(W_CLR, 4'hF, 32'hFFFF_0003, "R7 upper half ignored");
    do_write(W_CLR, 4'b0010, 32'h0000_FFFF, "R7 lane limited");
    do_write(W_IN, 4'hF, 32'hFFFF_FFFF, "R9 input write ignored");
    do_write(W_NONE, 4'hF, 32'hFFFF_FFFF, "R11 unmapped write");
    do_read(W_SR, rv);
    check(rv == '0, "R8 combined reads zero", rv, '0);
    do_read(W_CLR, rv);
    check(rv == '0, "R8 clear-only reads zero", rv, '0);
    do_read(W_NONE, rv);
    check(rv == '0, "R11 unmapped read", rv, '0);

    // R9: synchronizer depth.
    @(negedge clk);
    pins_in = 16'hBEEF;
    do_read(W_IN, rv);
    check(rv == '0, "R9 not yet visible", rv, '0);
    do_read(W_IN, rv);
    check(rv == 32'h0000_BEEF, "R9 visible", rv, 32'h0000_BEEF);

    // Random mix across all registers.
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      case ($urandom_range(0, 4))
        0: a = W_OUT; 1: a = W_SR; 2: a = W_CLR; 3: a = W_IN;
        default: a = W_NONE;
      endcase
      if ($urandom_range(0, 3) == 0) begin
        do_read(a, rv);
        if (a == W_OUT)
          check(rv == DW'(exp_out), "R2 random read", rv, DW'(exp_out));
        else if (a == W_IN)
          check(rv == 32'h0000_BEEF, "R9 random read", rv, 32'h0000_BEEF);
        else
          check(rv == '0, "R8 R11 random read", rv, '0);
      end else begin
        do_write(a, 4'($urandom), $urandom, "R3 R4 R6 R7 random write");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule